// File: doc/BRIEF.md
# Gated Multi-Mode Timer/Counter

This block counts events in one of three layouts built from a high byte and a low byte. In the 13-bit layout, the five low bits of the low byte act as a prescaler that feeds the high byte. In the 16-bit layout, the two bytes form a single cascaded counter. In the reload layout, the low byte counts alone and is refilled from the high byte each time it wraps. Each count step comes from one of two sources: a strobe taken from the core clock divided by six, or a falling edge on an external pin after a two-flop synchroniser.

Counting is allowed only while the run input is high. When gating is selected, a second synchronised pin must also be high. A wrap of the active count bits sets a sticky overflow flag, which drives the interrupt request. An acknowledge input clears the flag. Software loads either byte through a write strobe and a data bus, and a write takes priority over a count step that falls in the same cycle. The external reset is asynchronous and active low, and its release is synchronised inside the block.

Top module: `gated_timer`

## Requirements
- R1: After reset, cnt_hi and cnt_lo read 0x00 and ovf_irq is 0.
- R2: With src_ext=0, exactly one count step occurs per six consecutive clock edges during which counting is enabled.
- R3: With src_ext=1, each falling edge of cnt_pin (1 to 0) yields one count step, and rising edges yield none. At most one step occurs per six-clock period, however fast the pin toggles.
- R4: With run_en=0 the count holds. With gate_en=1 and gate_pin low the count holds. With gate_en=1 and gate_pin high counting proceeds.
- R5: mode_sel=0 (13-bit): bits [4:0] of cnt_lo count modulo 32. Their wrap from 0x1F to 0x00 adds one to cnt_hi. Bits [7:5] of cnt_lo keep their value.
- R6: In mode_sel=0, a step with cnt_hi=0xFF and cnt_lo[4:0]=0x1F clears both of those fields and sets ovf_irq, whatever cnt_lo[7:5] holds.
- R7: mode_sel=1 and mode_sel=3 (16-bit): {cnt_hi,cnt_lo} increments as one 16-bit value.
- R8: In 16-bit mode a step from 0xFFFF gives 0x0000 and sets ovf_irq.
- R9: mode_sel=2 (reload): only cnt_lo counts. A step from cnt_lo=0xFF loads cnt_lo with cnt_hi, sets ovf_irq and leaves cnt_hi unchanged. A new cnt_hi value is used at the next wrap.
- R10: int_ack high for one cycle clears ovf_irq at that edge. If an overflow occurs at the same edge, ovf_irq stays set.
- R11: A write (wr_hi or wr_lo with wr_data) sets that byte at the next edge, overriding a count step in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | 0: 13-bit, 1/3: 16-bit, 2: 8-bit reload |
| src_ext | input | 1 | 0: clock divided by six, 1: cnt_pin falling edges |
| run_en | input | 1 | Counting enable |
| gate_en | input | 1 | Requires gate_pin high for counting |
| gate_pin | input | 1 | External gate level (asynchronous) |
| cnt_pin | input | 1 | External count input (asynchronous) |
| wr_hi | input | 1 | Load high byte from wr_data |
| wr_lo | input | 1 | Load low byte from wr_data |
| wr_data | input | 8 | Write data |
| int_ack | input | 1 | Interrupt acknowledge, clears the flag |
| cnt_hi | output | 8 | High byte of the count |
| cnt_lo | output | 8 | Low byte of the count |
| ovf_irq | output | 1 | Overflow flag / interrupt request |

## Verification
Count bytes and the flag are registered and change at the edge where a step is taken, so they are read at the following falling clock edge. The internal source steps on a fixed phase that the bench cannot see. The bench therefore enables counting for exactly 6·N edges, which always holds exactly N steps whatever the phase. Where a write or an acknowledge must land on the same edge as a step, the bench first watches cnt_lo change to find that edge, then drives the input five edges later so it meets the sixth. Pin-based stimulus (gate and count pins) passes two synchroniser flops and an edge register, so the bench waits several cycles after each pin change before it relies on it.

// File: rtl/gt_pkg.sv
package gt_pkg;
  typedef enum logic [1:0] {
    MODE_13   = 2'd0,
    MODE_16   = 2'd1,
    MODE_RLD  = 2'd2,
    MODE_16B  = 2'd3
  } gt_mode_e;
endpackage

// File: rtl/gt_sync.sv
module gt_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = d_async;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], d_async};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/gt_tick_gen.sv
module gt_tick_gen #(
  parameter int DIV         = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src_ext,
  input  logic run_en,
  input  logic gate_en,
  input  logic gate_pin,
  input  logic cnt_pin,
  output logic cnt_tick
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(DIV - 1);

  logic [DW-1:0] div_q, div_d;
  logic          div_strobe;
  logic          pin_s, gate_s;
  logic          pin_prev_q;
  logic          pin_fall;
  logic          pend_q, pend_d;
  logic          ext_evt;
  logic          src_evt;
  logic          gate_ok;

  gt_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync (
    .clk(clk), .rst_n(rst_n), .d_async(cnt_pin), .q_sync(pin_s)
  );

  gt_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_gate_sync (
    .clk(clk), .rst_n(rst_n), .d_async(gate_pin), .q_sync(gate_s)
  );

  // free-running divider for the internal source and the external rate limit
  always_comb begin
    div_strobe = (div_q == DIV_LAST);
    div_d      = div_strobe ? '0 : div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  // falling-edge capture; a pending edge is consumed at the next strobe
  always_comb begin
    pin_fall = pin_prev_q & ~pin_s;
    ext_evt  = div_strobe & (pend_q | pin_fall);
    pend_d   = div_strobe ? 1'b0 : (pend_q | pin_fall);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_prev_q <= 1'b1;
      pend_q     <= 1'b0;
    end else begin
      pin_prev_q <= pin_s;
      pend_q     <= pend_d;
    end
  end

  always_comb begin
    src_evt  = src_ext ? ext_evt : div_strobe;
    gate_ok  = ~gate_en | gate_s;
    cnt_tick = src_evt & run_en & gate_ok;
  end

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_tick |=> !cnt_tick); // R2

  AST_EXT_RATE: assert property (@(posedge clk) disable iff (!rst_n)
    (src_ext && ext_evt) |=> !ext_evt); // R3
endmodule

// File: rtl/gt_count_core.sv
module gt_count_core
  import gt_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int PRESC_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  gt_mode_e          mode,
  input  logic              inc,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] hi_q,
  output logic [BYTE_W-1:0] lo_q,
  output logic              ovf
);
  localparam int FULL_W = 2 * BYTE_W;

  logic [BYTE_W-1:0] hi_d, lo_d;
  logic [FULL_W-1:0] full_inc;
  logic              ld_en;

  always_comb begin
    full_inc = {hi_q, lo_q} + 1'b1;
    hi_d     = hi_q;
    lo_d     = lo_q;
    ovf      = 1'b0;
    if (inc) begin
      case (mode)
        MODE_13: begin
          if (&lo_q[PRESC_W-1:0]) begin
            lo_d[PRESC_W-1:0] = '0;
            hi_d              = hi_q + 1'b1;
            ovf               = &hi_q;
          end else begin
            lo_d[PRESC_W-1:0] = lo_q[PRESC_W-1:0] + 1'b1;
          end
        end
        MODE_RLD: begin
          if (&lo_q) begin
            lo_d = hi_q;
            ovf  = 1'b1;
          end else begin
            lo_d = lo_q + 1'b1;
          end
        end
        default: begin
          {hi_d, lo_d} = full_inc;
          ovf          = &{hi_q, lo_q};
        end
      endcase
    end
    if (wr_hi) hi_d = wr_data;
    if (wr_lo) lo_d = wr_data;
    ld_en = inc | wr_hi | wr_lo;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (ld_en) begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  AST_PRESC_TOP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_13 && !wr_lo) |=> lo_q[BYTE_W-1:PRESC_W] == $past(lo_q[BYTE_W-1:PRESC_W])); // R5

  AST_RELOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_RLD && ovf && !wr_lo) |=> lo_q == $past(hi_q)); // R9

  AST_RELOAD_HI_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_RLD && !wr_hi) |=> hi_q == $past(hi_q)); // R9

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> lo_q == $past(wr_data)); // R11

  AST_WRAP_ZERO16: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && (mode == MODE_16 || mode == MODE_16B) && !wr_hi && !wr_lo)
      |=> (hi_q == '0 && lo_q == '0)); // R8
endmodule

// File: rtl/gt_ovf_flag.sv
module gt_ovf_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic ovf,
  input  logic ack,
  output logic flag_q
);
  logic flag_d;

  always_comb flag_d = ovf | (flag_q & ~ack);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  AST_FLAG_ON_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> flag_q); // R10

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !ovf) |=> !flag_q); // R10

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !ack) |=> flag_q); // R10
endmodule

// File: rtl/gated_timer.sv
module gated_timer
  import gt_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int PRESC_W     = 5,
  parameter int DIV         = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_sel,
  input  logic              src_ext,
  input  logic              run_en,
  input  logic              gate_en,
  input  logic              gate_pin,
  input  logic              cnt_pin,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              int_ack,
  output logic [BYTE_W-1:0] cnt_hi,
  output logic [BYTE_W-1:0] cnt_lo,
  output logic              ovf_irq
);
  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  logic       cnt_tick;
  logic       ovf;
  gt_mode_e   mode;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  assign mode = gt_mode_e'(mode_sel);

  gt_tick_gen #(.DIV(DIV), .SYNC_STAGES(SYNC_STAGES)) u_tick (
    .clk(clk), .rst_n(rst_core_n), .src_ext(src_ext), .run_en(run_en),
    .gate_en(gate_en), .gate_pin(gate_pin), .cnt_pin(cnt_pin),
    .cnt_tick(cnt_tick)
  );

  gt_count_core #(.BYTE_W(BYTE_W), .PRESC_W(PRESC_W)) u_core (
    .clk(clk), .rst_n(rst_core_n), .mode(mode), .inc(cnt_tick),
    .wr_hi(wr_hi), .wr_lo(wr_lo), .wr_data(wr_data),
    .hi_q(cnt_hi), .lo_q(cnt_lo), .ovf(ovf)
  );

  gt_ovf_flag u_flag (
    .clk(clk), .rst_n(rst_core_n), .ovf(ovf), .ack(int_ack), .flag_q(ovf_irq)
  );

  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!run_en && !wr_hi && !wr_lo) |=> ($stable(cnt_hi) && $stable(cnt_lo))); // R4

  AST_NO_SPURIOUS_FLAG: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!ovf_irq && !cnt_tick) |=> !ovf_irq); // R10
endmodule

// File: tb/gated_timer_tb.sv
module gated_timer_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] mode_sel;
  logic       src_ext, run_en, gate_en, gate_pin, cnt_pin;
  logic       wr_hi, wr_lo, int_ack;
  logic [7:0] wr_data;
  logic [7:0] cnt_hi, cnt_lo;
  logic       ovf_irq;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gated_timer u_dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .src_ext(src_ext),
    .run_en(run_en), .gate_en(gate_en), .gate_pin(gate_pin), .cnt_pin(cnt_pin),
    .wr_hi(wr_hi), .wr_lo(wr_lo), .wr_data(wr_data), .int_ack(int_ack),
    .cnt_hi(cnt_hi), .cnt_lo(cnt_lo), .ovf_irq(ovf_irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic put(input logic hi, input logic lo, input logic [7:0] d);
    wr_hi = hi; wr_lo = lo; wr_data = d;
    @(negedge clk);
    wr_hi = 1'b0; wr_lo = 1'b0;
  endtask

  task automatic load(input logic [7:0] h, input logic [7:0] l);
    put(1'b1, 1'b1, l);
    put(1'b1, 1'b0, h);
  endtask

  task automatic steps(input int n);
    run_en = 1'b1;
    repeat (6 * n) @(negedge clk);
    run_en = 1'b0;
  endtask

  task automatic ack_pulse();
    int_ack = 1'b1;
    @(negedge clk);
    int_ack = 1'b0;
  endtask

  // wait with run on until cnt_lo equals v; then the next step is 6 edges on
  task automatic align(input logic [7:0] v);
    for (int i = 0; i < 20 && cnt_lo != v; i++) @(negedge clk);
    chk("align", cnt_lo, v);
  endtask

  task automatic t_reset();
    chk("R1 hi", cnt_hi, 8'h00);
    chk("R1 lo", cnt_lo, 8'h00);
    chk("R1 irq", ovf_irq, 0);
  endtask

  task automatic t_internal();
    mode_sel = 2'd1; src_ext = 1'b0;
    load(8'h00, 8'h00);
    steps(7);
    chk("R2 seven steps", cnt_lo, 8'h07);
    steps(1);
    chk("R2 one step", cnt_lo, 8'h08);
  endtask

  task automatic t_gate();
    mode_sel = 2'd1; src_ext = 1'b0;
    load(8'h00, 8'h00);
    gate_en = 1'b1; gate_pin = 1'b0;
    repeat (5) @(negedge clk);
    steps(10);
    chk("R4 gate low holds", cnt_lo, 8'h00);
    gate_pin = 1'b1;
    repeat (5) @(negedge clk);
    steps(10);
    chk("R4 gate high counts", cnt_lo, 8'h0A);
    repeat (60) @(negedge clk);
    chk("R4 run low holds", cnt_lo, 8'h0A);
    gate_en = 1'b0;
  endtask

  task automatic t_external();
    int c;
    mode_sel = 2'd1; src_ext = 1'b1;
    load(8'h00, 8'h00);
    run_en = 1'b1;
    repeat (20) @(negedge clk);
    chk("R3 no clock steps", cnt_lo, 8'h00);
    for (int p = 0; p < 3; p++) begin
      cnt_pin = 1'b0; repeat (12) @(negedge clk);
      cnt_pin = 1'b1; repeat (12) @(negedge clk);
    end
    chk("R3 three falls", cnt_lo, 8'h03);
    for (int t = 0; t < 60; t++) begin
      cnt_pin = ~cnt_pin;
      @(negedge clk);
    end
    cnt_pin = 1'b1;
    repeat (20) @(negedge clk);
    run_en = 1'b0;
    c = int'(cnt_lo) - 3;
    n_chk++;
    if (c < 9 || c > 11) begin
      n_fail++;
      $display("FAIL R3 rate limit: actual %0d expected 9..11", c);
    end
    src_ext = 1'b0;
  endtask

  task automatic t_mode13();
    mode_sel = 2'd0;
    load(8'h12, 8'hFE);
    steps(2);
    chk("R5 carry hi", cnt_hi, 8'h13);
    chk("R5 top bits held", cnt_lo, 8'hE0);
    steps(3);
    chk("R5 presc count", cnt_lo, 8'hE3);
    ack_pulse();
    load(8'hFF, 8'hBF);
    steps(1);
    chk("R6 hi wrap", cnt_hi, 8'h00);
    chk("R6 lo wrap", cnt_lo, 8'hA0);
    chk("R6 flag", ovf_irq, 1);
    ack_pulse();
    chk("R10 ack clears", ovf_irq, 0);
  endtask

  task automatic t_mode16();
    mode_sel = 2'd1;
    load(8'h12, 8'hFF);
    steps(1);
    chk("R7 carry", {cnt_hi, cnt_lo}, 16'h1300);
    mode_sel = 2'd3;
    steps(1);
    chk("R7 mode3 as 16", {cnt_hi, cnt_lo}, 16'h1301);
    chk("R7 no flag", ovf_irq, 0);
    mode_sel = 2'd1;
    load(8'hFF, 8'hFF);
    steps(1);
    chk("R8 wrap", {cnt_hi, cnt_lo}, 16'h0000);
    chk("R8 flag", ovf_irq, 1);
    ack_pulse();
  endtask

  task automatic t_reload();
    mode_sel = 2'd2;
    load(8'h40, 8'h10);
    steps(1);
    chk("R9 lo only", cnt_lo, 8'h11);
    chk("R9 hi kept", cnt_hi, 8'h40);
    load(8'h40, 8'hFE);
    steps(2);
    chk("R9 reload", cnt_lo, 8'h40);
    chk("R9 hi after reload", cnt_hi, 8'h40);
    chk("R9 flag", ovf_irq, 1);
    ack_pulse();
    put(1'b1, 1'b0, 8'h80);
    put(1'b0, 1'b1, 8'hFF);
    steps(1);
    chk("R9 new reload", cnt_lo, 8'h80);
    ack_pulse();
  endtask

  task automatic t_ack_collide();
    mode_sel = 2'd1;
    load(8'hFF, 8'hFF);
    steps(1);
    chk("R10 flag preset", ovf_irq, 1);
    load(8'hFF, 8'hFE);
    run_en = 1'b1;
    align(8'hFF);
    repeat (5) @(negedge clk);
    int_ack = 1'b1;
    @(negedge clk);
    int_ack = 1'b0;
    run_en = 1'b0;
    chk("R10 collide wrap", {cnt_hi, cnt_lo}, 16'h0000);
    chk("R10 collide stays set", ovf_irq, 1);
    ack_pulse();
  endtask

  task automatic t_write_prio();
    mode_sel = 2'd1;
    load(8'h00, 8'h20);
    run_en = 1'b1;
    align(8'h21);
    repeat (5) @(negedge clk);
    wr_lo = 1'b1; wr_data = 8'h55;
    @(negedge clk);
    wr_lo = 1'b0;
    run_en = 1'b0;
    chk("R11 write wins", cnt_lo, 8'h55);
    chk("R11 hi untouched", cnt_hi, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode_sel = 2'd1; src_ext = 1'b0; run_en = 1'b0;
    gate_en = 1'b0; gate_pin = 1'b0; cnt_pin = 1'b1;
    wr_hi = 1'b0; wr_lo = 1'b0; wr_data = 8'h00; int_ack = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_internal();
    t_gate();
    t_external();
    t_mode13();
    t_mode16();
    t_reload();
    t_ack_collide();
    t_write_prio();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule